// File: doc/BRIEF.md
# Partial M-Smallest Index Sorter

This block is the ordering stage of a tree-search detector. Candidate path metrics sit in a metric RAM that other logic has already filled. The block permutes a separate index RAM, which holds the identity sequence 0..len-1 when `start` arrives, so that its first M entries name the M smallest metrics in ascending order. The block never moves the metrics. It only rearranges the indices that point at them.

A single state machine runs an iterative quicksort. The pivot is the median of the first, middle and last elements of the range. Pending subranges are not handled by recursion. Their bounds go into a small stack memory instead, and the larger half is pushed first, so that the smaller half is popped and handled first. A subrange that starts at or beyond position M is dropped and never pushed. A range no longer than a threshold is finished by insertion sort. Each RAM has one port, and every read returns its data one cycle after the address is presented. The machine waits out that latency itself. `done` pulses for one cycle once the stack has drained.

Top module: `msel_sorter`

## Requirements
- R1: After `done`, index positions 0..min(M,len)-1 name elements whose metrics are, in that order, equal to the min(M,len) smallest metrics of the sequence, sorted nondecreasing.
- R2: After `done`, index positions 0..len-1 hold a permutation of 0..len-1.
- R3: Equal metrics, including a sequence whose metrics are all equal, produce a correct result under R1 and R2.
- R4: Each accepted `start` yields exactly one `done` pulse lasting one cycle. With len below 2 or M equal to 0, `done` follows without any index RAM write.
- R5: `stack_ovf` goes high when a range must be pushed onto a full stack. It stays high until the next accepted `start` clears it, and `done` is still produced.
- R6: The index RAM is written only during a run, and only at addresses below len. Entries at len and above keep their values.
- R7: Presorted input, reverse-sorted input, and M at or above len (which orders the whole sequence) all meet R1.
- R8: A `start` pulse that arrives while a run is in progress is ignored. The run completes with a single `done`, and its result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only when idle |
| seq_len | input | $clog2(LMAX)+1 | Number of elements, sampled at start |
| keep_cnt | input | $clog2(LMAX)+1 | M, the number of smallest elements to order, sampled at start |
| done | output | 1 | One-cycle pulse at the end of a run |
| stack_ovf | output | 1 | Sticky flag: a push met a full stack |
| idx_addr | output | $clog2(LMAX) | Index RAM address |
| idx_we | output | 1 | Index RAM write enable |
| idx_wdata | output | $clog2(LMAX) | Index RAM write data |
| idx_rdata | input | $clog2(LMAX) | Index RAM read data, one cycle after address |
| met_addr | output | $clog2(LMAX) | Metric RAM address |
| met_rdata | input | MW | Metric RAM read data, one cycle after address |

## Verification
Most corrupted internal state lands in the index RAM. A wrong hole or scan pointer, a mis-chosen pivot, or a lost write shows up as a front entry whose metric is out of order, or as a duplicated or missing index, and either is visible as soon as `done` is seen. A wrong stack pointer or a wrong pruning decision either leaves front positions unsorted at `done` or keeps `done` from ever arriving, which the run's cycle limit catches. A write address that is out of range shows at the port in the same cycle as the write, and it also leaves a changed entry above len.

// File: rtl/msel_pkg.sv
package msel_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_RANGE, S_POP, S_POPW,
        S_FE_I, S_FE_M, S_FE_D,
        S_IS_KEY, S_IS_GOT, S_IS_CMP, S_IS_PUT,
        S_MD_A, S_MD_B, S_MD_C, S_MD_SEL, S_MD_SW1, S_MD_SW2,
        S_PT_LOOP, S_PT_CMP, S_PT_RI, S_PT_RW, S_PT_W2,
        S_PT_EI, S_PT_EW, S_PT_EW2,
        S_PUSH_A, S_PUSH_B, S_DONE
    } sort_state_e;

    typedef enum logic [1:0] {
        PICK_LO,
        PICK_MID,
        PICK_HI
    } pick_e;

endpackage

// File: rtl/msel_pivot.sv
module msel_pivot
    import msel_pkg::*;
#(
    parameter int MW = 16
) (
    input  logic [MW-1:0] m_lo,
    input  logic [MW-1:0] m_mid,
    input  logic [MW-1:0] m_hi,
    output pick_e         pick
);
    always_comb begin
        if (m_lo <= m_mid) begin
            if (m_mid <= m_hi)     pick = PICK_MID;
            else if (m_lo <= m_hi) pick = PICK_HI;
            else                   pick = PICK_LO;
        end else begin
            if (m_lo <= m_hi)      pick = PICK_LO;
            else if (m_mid <= m_hi) pick = PICK_HI;
            else                   pick = PICK_MID;
        end
    end
endmodule

// File: rtl/msel_stack.sv
module msel_stack #(
    parameter int PW    = 13,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [PW-1:0] push_lo,
    input  logic [PW-1:0] push_hi,
    input  logic          pop,
    output logic [PW-1:0] pop_lo,
    output logic [PW-1:0] pop_hi,
    output logic          empty,
    output logic          full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int SA = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [2*PW-1:0] mem [DEPTH];
    logic [CW-1:0]   ptr;
    logic [CW-1:0]   ptr_m1;
    logic [2*PW-1:0] rd_q;

    assign ptr_m1 = ptr - CW'(1);
    assign empty  = (ptr == '0);
    assign full   = (ptr == CW'(DEPTH));
    assign pop_lo = rd_q[2*PW-1:PW];
    assign pop_hi = rd_q[PW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (push && !full) begin
            ptr <= ptr + CW'(1);
        end else if (pop && !empty) begin
            ptr <= ptr_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[ptr[SA-1:0]] <= {push_lo, push_hi};
        if (pop && !empty) rd_q <= mem[ptr_m1[SA-1:0]];
    end
endmodule

// File: rtl/msel_sorter.sv
module msel_sorter
    import msel_pkg::*;
#(
    parameter int LMAX        = 4096,
    parameter int MW          = 16,
    parameter int INS_THRESH  = 8,
    parameter int STACK_DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [$clog2(LMAX):0]   seq_len,
    input  logic [$clog2(LMAX):0]   keep_cnt,
    output logic                    done,
    output logic                    stack_ovf,
    output logic [$clog2(LMAX)-1:0] idx_addr,
    output logic                    idx_we,
    output logic [$clog2(LMAX)-1:0] idx_wdata,
    input  logic [$clog2(LMAX)-1:0] idx_rdata,
    output logic [$clog2(LMAX)-1:0] met_addr,
    input  logic [MW-1:0]           met_rdata
);
    localparam int AW = $clog2(LMAX);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] ONE = PW'(1);
    localparam logic [PW-1:0] THR = PW'(INS_THRESH);

    typedef logic [PW-1:0] pos_t;
    typedef logic [AW-1:0] id_t;
    typedef logic [MW-1:0] met_t;

    sort_state_e state, ret;
    pos_t lo, hi, keep_q, kpos, hpos, ipos, jpos, f_pos, p_pos;
    id_t  f_id, key_id, a_id, b_id, c_id, pid, t_id;
    met_t f_met, key_met, a_met, b_met, pv;
    logic ovf_q;

    pos_t  mid_pos;
    pick_e pick;
    logic  push, pop, stk_empty, stk_full;
    pos_t  push_lo, push_hi, pop_lo, pop_hi;
    logic  l_ok, r_ok, big_left;

    assign mid_pos  = lo + ((hi - lo) >> 1);
    assign l_ok     = ipos > lo + ONE;
    assign r_ok     = (hi > ipos + ONE) && (ipos + ONE < keep_q);
    assign big_left = (ipos - lo) >= (hi - ipos);
    assign done      = (state == S_DONE);
    assign stack_ovf = ovf_q;

    msel_pivot #(.MW(MW)) pivot_i (
        .m_lo(a_met), .m_mid(b_met), .m_hi(f_met), .pick(pick)
    );

    msel_stack #(.PW(PW), .DEPTH(STACK_DEPTH)) stack_i (
        .clk(clk), .rst(rst), .push(push), .push_lo(push_lo), .push_hi(push_hi),
        .pop(pop), .pop_lo(pop_lo), .pop_hi(pop_hi), .empty(stk_empty), .full(stk_full)
    );

    // RAM ports and stack commands, decoded from the current state
    always_comb begin
        idx_addr  = '0;
        idx_we    = 1'b0;
        idx_wdata = '0;
        met_addr  = '0;
        push      = 1'b0;
        pop       = 1'b0;
        push_lo   = '0;
        push_hi   = '0;
        case (state)
            S_FE_I:   idx_addr = f_pos[AW-1:0];
            S_FE_M:   met_addr = idx_rdata;
            S_IS_CMP: if (f_met > key_met) begin
                          idx_we = 1'b1; idx_addr = hpos[AW-1:0]; idx_wdata = f_id;
                      end
            S_IS_PUT: begin idx_we = 1'b1; idx_addr = hpos[AW-1:0]; idx_wdata = key_id; end
            S_MD_SW1: begin idx_we = 1'b1; idx_addr = hi[AW-1:0];   idx_wdata = pid;    end
            S_MD_SW2: begin idx_we = 1'b1; idx_addr = p_pos[AW-1:0]; idx_wdata = c_id;  end
            S_PT_RI,
            S_PT_EI:  idx_addr = ipos[AW-1:0];
            S_PT_RW:  begin idx_we = 1'b1; idx_addr = ipos[AW-1:0]; idx_wdata = f_id;   end
            S_PT_W2:  begin idx_we = 1'b1; idx_addr = jpos[AW-1:0]; idx_wdata = t_id;   end
            S_PT_EW:  begin idx_we = 1'b1; idx_addr = ipos[AW-1:0]; idx_wdata = pid;    end
            S_PT_EW2: begin idx_we = 1'b1; idx_addr = hi[AW-1:0];   idx_wdata = t_id;   end
            S_POP:    pop = !stk_empty;
            S_PUSH_A: begin
                push = l_ok | r_ok;
                if ((l_ok && r_ok) ? big_left : l_ok) begin
                    push_lo = lo;         push_hi = ipos - ONE;
                end else begin
                    push_lo = ipos + ONE; push_hi = hi;
                end
            end
            S_PUSH_B: begin
                push = l_ok & r_ok;
                if (big_left) begin
                    push_lo = ipos + ONE; push_hi = hi;
                end else begin
                    push_lo = lo;         push_hi = ipos - ONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ret   <= S_IDLE;
            ovf_q <= 1'b0;
            lo <= '0; hi <= '0; keep_q <= '0; kpos <= '0; hpos <= '0;
            ipos <= '0; jpos <= '0; f_pos <= '0; p_pos <= '0;
            f_id <= '0; key_id <= '0; a_id <= '0; b_id <= '0; c_id <= '0; pid <= '0; t_id <= '0;
            f_met <= '0; key_met <= '0; a_met <= '0; b_met <= '0; pv <= '0;
        end else begin
            if (push && stk_full) ovf_q <= 1'b1;
            case (state)
                S_IDLE: if (start) begin
                    ovf_q  <= 1'b0;
                    lo     <= '0;
                    hi     <= seq_len - ONE;
                    keep_q <= keep_cnt;
                    state  <= (seq_len < PW'(2) || keep_cnt == '0) ? S_DONE : S_RANGE;
                end
                S_RANGE: begin
                    kpos  <= lo + ONE;
                    state <= ((hi - lo) < THR) ? S_IS_KEY : S_MD_A;
                end
                S_POP:  state <= stk_empty ? S_DONE : S_POPW;
                S_POPW: begin lo <= pop_lo; hi <= pop_hi; state <= S_RANGE; end
                // element fetch: index, then metric, then return
                S_FE_I: state <= S_FE_M;
                S_FE_M: begin f_id <= idx_rdata; state <= S_FE_D; end
                S_FE_D: begin f_met <= met_rdata; state <= ret; end
                // insertion sort of a short range
                S_IS_KEY: begin f_pos <= kpos; ret <= S_IS_GOT; state <= S_FE_I; end
                S_IS_GOT: begin
                    key_id <= f_id; key_met <= f_met; hpos <= kpos;
                    f_pos <= kpos - ONE; ret <= S_IS_CMP; state <= S_FE_I;
                end
                S_IS_CMP: begin
                    if (f_met > key_met) begin
                        hpos <= hpos - ONE;
                        if (hpos - ONE == lo) state <= S_IS_PUT;
                        else begin f_pos <= hpos - PW'(2); ret <= S_IS_CMP; state <= S_FE_I; end
                    end else begin
                        state <= S_IS_PUT;
                    end
                end
                S_IS_PUT: begin
                    kpos  <= kpos + ONE;
                    state <= (kpos == hi) ? S_POP : S_IS_KEY;
                end
                // median-of-three pivot, moved to the right end
                S_MD_A: begin f_pos <= lo; ret <= S_MD_B; state <= S_FE_I; end
                S_MD_B: begin a_id <= f_id; a_met <= f_met; f_pos <= mid_pos; ret <= S_MD_C; state <= S_FE_I; end
                S_MD_C: begin b_id <= f_id; b_met <= f_met; f_pos <= hi; ret <= S_MD_SEL; state <= S_FE_I; end
                S_MD_SEL: begin
                    c_id <= f_id; ipos <= lo; jpos <= lo;
                    case (pick)
                        PICK_LO:  begin pv <= a_met; pid <= a_id; p_pos <= lo;      end
                        PICK_MID: begin pv <= b_met; pid <= b_id; p_pos <= mid_pos; end
                        default:  begin pv <= f_met; pid <= f_id; p_pos <= hi;      end
                    endcase
                    state <= (pick == PICK_HI) ? S_PT_LOOP : S_MD_SW1;
                end
                S_MD_SW1: state <= S_MD_SW2;
                S_MD_SW2: state <= S_PT_LOOP;
                // partition scan
                S_PT_LOOP: begin
                    if (jpos == hi) state <= S_PT_EI;
                    else begin f_pos <= jpos; ret <= S_PT_CMP; state <= S_FE_I; end
                end
                S_PT_CMP: begin
                    if (f_met < pv) begin
                        if (ipos == jpos) begin
                            ipos <= ipos + ONE; jpos <= jpos + ONE; state <= S_PT_LOOP;
                        end else begin
                            state <= S_PT_RI;
                        end
                    end else begin
                        jpos <= jpos + ONE; state <= S_PT_LOOP;
                    end
                end
                S_PT_RI: state <= S_PT_RW;
                S_PT_RW: begin t_id <= idx_rdata; state <= S_PT_W2; end
                S_PT_W2: begin ipos <= ipos + ONE; jpos <= jpos + ONE; state <= S_PT_LOOP; end
                S_PT_EI:  state <= S_PT_EW;
                S_PT_EW:  begin t_id <= idx_rdata; state <= S_PT_EW2; end
                S_PT_EW2: state <= S_PUSH_A;
                S_PUSH_A: state <= S_PUSH_B;
                S_PUSH_B: state <= S_POP;
                S_DONE:   state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msel_sorter_chk.sv
module msel_sorter_chk #(
    parameter int LMAX = 4096
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic [$clog2(LMAX):0]   seq_len,
    input logic                    done,
    input logic                    stack_ovf,
    input logic                    idx_we,
    input logic [$clog2(LMAX)-1:0] idx_addr
);
    logic                  busy;
    logic [$clog2(LMAX):0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            len_q <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            len_q <= seq_len;
        end
    end

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r4_done_in_run: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    a_r6_write_in_range: assert property (@(posedge clk) disable iff (rst)
        idx_we |-> (busy && ({1'b0, idx_addr} < len_q)));
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (stack_ovf && !start) |=> stack_ovf);
    a_r5_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !stack_ovf);
endmodule

bind msel_sorter msel_sorter_chk #(.LMAX(LMAX)) chk_i (
    .clk(clk), .rst(rst), .start(start), .seq_len(seq_len), .done(done),
    .stack_ovf(stack_ovf), .idx_we(idx_we), .idx_addr(idx_addr)
);

// File: tb/msel_sorter_tb_top.sv
module msel_tb_ram #(
    parameter int AW = 6,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          init,
    input  logic [AW-1:0] idx_addr,
    input  logic          idx_we,
    input  logic [AW-1:0] idx_wdata,
    output logic [AW-1:0] idx_rdata,
    input  logic [AW-1:0] met_addr,
    output logic [MW-1:0] met_rdata
);
    logic [MW-1:0] met [2**AW];
    logic [AW-1:0] idx [2**AW];

    always @(posedge clk) begin
        if (init) begin
            for (int k = 0; k < 2**AW; k++) idx[k] <= AW'(k);
        end else if (idx_we) begin
            idx[idx_addr] <= idx_wdata;
        end
        idx_rdata <= idx[idx_addr];
        met_rdata <= met[met_addr];
    end
endmodule

module msel_sorter_tb_top;
    localparam int LMAX = 64;
    localparam int AW   = 6;
    localparam int MW   = 8;
    localparam int LIMIT = 40000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // main instance
    logic          start = 1'b0, init = 1'b0;
    logic [AW:0]   seq_len = '0, keep_cnt = '0;
    logic          done, stack_ovf, idx_we;
    logic [AW-1:0] idx_addr, idx_wdata, idx_rdata, met_addr;
    logic [MW-1:0] met_rdata;

    msel_sorter #(.LMAX(LMAX), .MW(MW), .INS_THRESH(4), .STACK_DEPTH(8)) dut_i (
        .clk(clk), .rst(rst), .start(start), .seq_len(seq_len), .keep_cnt(keep_cnt),
        .done(done), .stack_ovf(stack_ovf), .idx_addr(idx_addr), .idx_we(idx_we),
        .idx_wdata(idx_wdata), .idx_rdata(idx_rdata), .met_addr(met_addr), .met_rdata(met_rdata)
    );
    msel_tb_ram #(.AW(AW), .MW(MW)) ram0_i (
        .clk(clk), .init(init), .idx_addr(idx_addr), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .idx_rdata(idx_rdata), .met_addr(met_addr), .met_rdata(met_rdata)
    );

    // second instance with a one-entry stack
    logic          start1 = 1'b0, init1 = 1'b0;
    logic [AW:0]   seq_len1 = '0, keep1 = '0;
    logic          done1, ovf1, idx_we1;
    logic [AW-1:0] idx_addr1, idx_wdata1, idx_rdata1, met_addr1;
    logic [MW-1:0] met_rdata1;

    msel_sorter #(.LMAX(LMAX), .MW(MW), .INS_THRESH(4), .STACK_DEPTH(1)) ovf_i (
        .clk(clk), .rst(rst), .start(start1), .seq_len(seq_len1), .keep_cnt(keep1),
        .done(done1), .stack_ovf(ovf1), .idx_addr(idx_addr1), .idx_we(idx_we1),
        .idx_wdata(idx_wdata1), .idx_rdata(idx_rdata1), .met_addr(met_addr1), .met_rdata(met_rdata1)
    );
    msel_tb_ram #(.AW(AW), .MW(MW)) ram1_i (
        .clk(clk), .init(init1), .idx_addr(idx_addr1), .idx_we(idx_we1), .idx_wdata(idx_wdata1),
        .idx_rdata(idx_rdata1), .met_addr(met_addr1), .met_rdata(met_rdata1)
    );

    int ref_sorted [LMAX];

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic void build_ref(input int n);
        for (int p = 0; p < n; p++) ref_sorted[p] = int'(ram0_i.met[p]);
        for (int p = 1; p < n; p++) begin
            int key = ref_sorted[p];
            int q = p - 1;
            while (q >= 0 && ref_sorted[q] > key) begin
                ref_sorted[q+1] = ref_sorted[q];
                q--;
            end
            ref_sorted[q+1] = key;
        end
    endfunction

    task automatic run(input int len, input int m, input bit restart, input string req);
        int cyc;
        int k;
        int bad;
        bit seen [LMAX];
        @(negedge clk); init = 1'b1;
        @(negedge clk); init = 1'b0;
        seq_len = (AW+1)'(len); keep_cnt = (AW+1)'(m);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (restart && cyc == 20) start = 1'b1;
            if (restart && cyc == 21) start = 1'b0;
        end
        if (!done) begin
            check(1'b0, "R4", "watchdog: done never seen", cyc, LIMIT);
            finish_run();
        end
        @(negedge clk);
        check(!done, "R4", "done longer than one cycle", int'(done), 0);
        if (restart) begin
            // R8: the extra start must not trigger a second run
            for (int w = 0; w < 40; w++) begin
                @(negedge clk);
                if (done) cyc = -1;
            end
            check(cyc >= 0, "R8", "second done after ignored start", 1, 0);
        end
        build_ref(len);
        k = (m < len) ? m : len;
        bad = -1;
        for (int p = 0; p < k; p++)
            if (int'(ram0_i.met[ram0_i.idx[p]]) != ref_sorted[p] && bad < 0) bad = p;
        if (bad >= 0)
            check(1'b0, req, $sformatf("front metric at pos %0d", bad),
                  int'(ram0_i.met[ram0_i.idx[bad]]), ref_sorted[bad]);
        else
            check(1'b1, req, "front order", 0, 0);
        bad = -1;
        for (int p = 0; p < len; p++) begin
            if (seen[ram0_i.idx[p]] || int'(ram0_i.idx[p]) >= len) begin
                if (bad < 0) bad = p;
            end
            seen[ram0_i.idx[p]] = 1'b1;
        end
        check(bad < 0, "R2", "index permutation", bad, -1);
        bad = -1;
        for (int p = len; p < LMAX; p++)
            if (int'(ram0_i.idx[p]) != p && bad < 0) bad = p;
        check(bad < 0, "R6", "entry beyond len changed", bad, -1);
    endtask

    task automatic run_ovf(input int len, input int exp_ovf);
        int cyc = 0;
        @(negedge clk); init1 = 1'b1;
        @(negedge clk); init1 = 1'b0;
        seq_len1 = (AW+1)'(len); keep1 = (AW+1)'(len);
        start1 = 1'b1;
        @(negedge clk); start1 = 1'b0;
        while (!done1 && cyc < LIMIT) begin @(negedge clk); cyc++; end
        check(done1, "R5", "done with small stack", int'(done1), 1);
        if (!done1) finish_run();
        check(int'(ovf1) == exp_ovf, "R5", "stack_ovf after run", int'(ovf1), exp_ovf);
        @(negedge clk);
        check(int'(ovf1) == exp_ovf, "R5", "stack_ovf held", int'(ovf1), exp_ovf);
    endtask

    initial begin
        int seed;
        int ident_bad;
        seed = $urandom(20240611);
        for (int p = 0; p < LMAX; p++) begin ram0_i.met[p] = '0; ram1_i.met[p] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done, "R4", "reset done", int'(done), 0);
        check(!stack_ovf, "R5", "reset stack_ovf", int'(stack_ovf), 0);
        check(!idx_we, "R6", "reset idx_we", int'(idx_we), 0);

        // R4: degenerate lengths and M = 0 leave the index array untouched
        for (int p = 0; p < LMAX; p++) ram0_i.met[p] = MW'(LMAX - p);
        run(1, 4, 1'b0, "R4");
        run(10, 0, 1'b0, "R4");
        ident_bad = -1;
        for (int p = 0; p < LMAX; p++) if (int'(ram0_i.idx[p]) != p && ident_bad < 0) ident_bad = p;
        check(ident_bad < 0, "R4", "index written on M=0 run", ident_bad, -1);

        // R1: wide random metrics
        for (int p = 0; p < LMAX; p++) ram0_i.met[p] = MW'($urandom);
        run(64, 8, 1'b0, "R1");
        run(2, 1, 1'b0, "R1");
        run(33, 1, 1'b0, "R1");

        // R7: presorted, reverse-sorted, M beyond len
        for (int p = 0; p < LMAX; p++) ram0_i.met[p] = MW'(p * 3);
        run(40, 40, 1'b0, "R7");
        for (int p = 0; p < LMAX; p++) ram0_i.met[p] = MW'(200 - p * 3);
        run(50, 10, 1'b0, "R7");
        for (int p = 0; p < LMAX; p++) ram0_i.met[p] = MW'($urandom);
        run(20, 63, 1'b0, "R7");

        // R3: all equal, and heavy ties
        for (int p = 0; p < LMAX; p++) ram0_i.met[p] = 8'd42;
        run(64, 64, 1'b0, "R3");
        for (int p = 0; p < LMAX; p++) ram0_i.met[p] = MW'($urandom % 4);
        run(64, 20, 1'b0, "R3");

        // R8: start during a run is ignored
        for (int p = 0; p < LMAX; p++) ram0_i.met[p] = MW'($urandom);
        run(64, 16, 1'b1, "R1");

        // constrained random mix
        for (int t = 0; t < 10; t++) begin
            int len = 2 + int'($urandom % 63);
            int m = 1 + int'($urandom % 64);
            bit narrow = ($urandom % 2) == 0;
            for (int p = 0; p < LMAX; p++)
                ram0_i.met[p] = narrow ? MW'($urandom % 8) : MW'($urandom);
            run(len, m, 1'b0, narrow ? "R3" : "R1");
        end

        // R5: overflow with a one-entry stack, then cleared by a new start
        ram1_i.met[0] = 8'd5; ram1_i.met[1] = 8'd1; ram1_i.met[2] = 8'd7;
        ram1_i.met[3] = 8'd3; ram1_i.met[4] = 8'd9; ram1_i.met[5] = 8'd2;
        ram1_i.met[6] = 8'd8; ram1_i.met[7] = 8'd4; ram1_i.met[8] = 8'd6;
        run_ovf(9, 1);
        run_ovf(3, 0);

        finish_run();
    end
endmodule